// File: doc/BRIEF.md
# Clock Synthesizer Configuration Bridge

This block lets a host processor reconfigure a clock synthesizer through a small memory-mapped register window on an AXI4-Lite slave. One register drives two reset/enable lines toward the synthesizer and its clocked logic. A second register takes a packed command word, and each accepted command performs exactly one access on the synthesizer's 16-bit dynamic reconfiguration port. A third register reports whether an access is still in flight and holds the data returned by the most recent port read.

The host runs a simple polling protocol. It waits for the busy flag to clear, writes a command, and then polls again. For a read, it takes the data once busy has dropped. Any masking of individual configuration fields is done in host software as a read followed by a write. The bridge itself moves whole 16-bit words only.

Top module: `clkcfg_bridge`

## Requirements
- R1: After reset, the control register and the status register both read 0. `gen_release_o`, `synth_en_o`, `drp_en_o` and `drp_we_o` are low, and no AXI response is pending.
- R2: A write to byte offset 0x40 stores data bits 1:0 and ignores all other bits. Bit 0 drives `gen_release_o` and bit 1 drives `synth_en_o`, both from the cycle after the write is accepted. Writing bit 0 set with bit 1 clear disables the synthesizer and keeps the general release. A read of 0x40 returns the stored two bits.
- R3: A write to offset 0x70 with bit 29 set and bit 28 clear starts one port write. In the cycle after acceptance, `drp_en_o` and `drp_we_o` are high for exactly one cycle. `drp_addr_o` carries data bits 22:16 and `drp_wdata_o` carries bits 15:0.
- R4: A write to 0x70 with bits 29 and 28 both set starts one port read: a one-cycle `drp_en_o` with `drp_we_o` low. The word on `drp_rdata_i` in the cycle `drp_rdy_i` is high appears in bits 15:0 of the status register at offset 0x74 from the next cycle on.
- R5: Status bit 16 (busy) is set from the cycle after a command starts up to and including the cycle in which `drp_rdy_i` is high, and is clear from the cycle after that.
- R6: A write to 0x70 with bit 29 clear starts no port access and leaves busy clear.
- R7: A write to 0x70 while busy is set is ignored. It produces no port access, it leaves the read-back value of 0x70 unchanged, and it does not disturb the access already in flight.
- R8: Reads of unmapped offsets return 0 with an OKAY (2'b00) response. Writes to unmapped offsets change no register and start nothing.
- R9: A write response stays valid until `s_bready` is seen, and no new write is accepted while it is pending. A read response and its data stay valid and unchanged until `s_rready` is seen.
- R10: A port write leaves status bits 15:0 holding the data of the last port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | AXI_AW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AXI_AW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| gen_release_o | output | 1 | General reset release (control bit 0) |
| synth_en_o | output | 1 | Synthesizer enable (control bit 1) |
| drp_en_o | output | 1 | Port access strobe, one cycle |
| drp_we_o | output | 1 | Port write qualifier, high only with the strobe |
| drp_addr_o | output | DRP_AW | Port register address |
| drp_wdata_o | output | DRP_DW | Port write data |
| drp_rdata_i | input | DRP_DW | Port read data |
| drp_rdy_i | input | 1 | Port access complete |

## Verification
Every result is registered once after the edge that causes it. Control outputs and the port strobe are due in the cycle after the AXI write is accepted, and the strobe is gone one cycle later. Status is a combinational read of registered state, so a status read accepted on the very edge where `drp_rdy_i` is seen must still show busy and the old data, while the next status read must show busy clear and the new word. The bench times its status reads against the moment the port model raises its ready signal so that both sides of this boundary are checked, and all samples are taken on the falling edge.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    // Register window offsets (bytes)
    localparam int unsigned OFS_CTL  = 32'h40;
    localparam int unsigned OFS_CMD  = 32'h70;
    localparam int unsigned OFS_STAT = 32'h74;

    // Host data path width
    localparam int unsigned HOST_DW = 32;

    // Command word layout
    localparam int unsigned CMD_SEL_BIT  = 29;
    localparam int unsigned CMD_RD_BIT   = 28;
    localparam int unsigned CMD_ADDR_LSB = 16;

    // Status word layout
    localparam int unsigned STAT_BUSY_BIT = 16;

    // Control register width
    localparam int unsigned CTL_W = 2;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_WAIT = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic                 bvalid;
        logic                 rvalid;
        logic [HOST_DW-1:0]   rdata;
    } axil_st_t;

endpackage

// File: rtl/clkcfg_axil.sv
module clkcfg_axil
    import clkcfg_pkg::*;
#(
    parameter int unsigned AXI_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AXI_AW-1:0]    s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [HOST_DW-1:0]   s_wdata,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [AXI_AW-1:0]    s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [HOST_DW-1:0]   s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready,
    output logic                 wr_fire_o,
    output logic [AXI_AW-1:0]    wr_addr_o,
    output logic [HOST_DW-1:0]   wr_data_o,
    output logic [AXI_AW-1:0]    rd_addr_o,
    input  logic [HOST_DW-1:0]   rd_data_i
);

    axil_st_t st_q, st_d;
    logic     rd_fire;

    // Address and data are taken together; one write outstanding at most.
    assign s_awready = s_wvalid  & ~st_q.bvalid;
    assign s_wready  = s_awvalid & ~st_q.bvalid;
    assign wr_fire_o = s_awvalid & s_wvalid & ~st_q.bvalid;
    assign s_arready = ~st_q.rvalid;
    assign rd_fire   = s_arvalid & ~st_q.rvalid;

    assign wr_addr_o = s_awaddr;
    assign wr_data_o = s_wdata;
    assign rd_addr_o = s_araddr;

    assign s_bvalid = st_q.bvalid;
    assign s_rvalid = st_q.rvalid;
    assign s_rdata  = st_q.rdata;
    assign s_bresp  = 2'b00;
    assign s_rresp  = 2'b00;

    always_comb begin
        st_d = st_q;
        if (wr_fire_o) begin
            st_d.bvalid = 1'b1;
        end else if (s_bready) begin
            st_d.bvalid = 1'b0;
        end
        if (rd_fire) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_data_i;
        end else if (s_rready) begin
            st_d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int unsigned AXI_AW = 8,
    parameter int unsigned DRP_AW = 7,
    parameter int unsigned DRP_DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_fire_i,
    input  logic [AXI_AW-1:0]    wr_addr_i,
    input  logic [HOST_DW-1:0]   wr_data_i,
    input  logic [AXI_AW-1:0]    rd_addr_i,
    output logic [HOST_DW-1:0]   rd_data_o,
    input  logic                 busy_i,
    input  logic [DRP_DW-1:0]    cap_i,
    output logic [CTL_W-1:0]     ctl_o,
    output logic                 start_o,
    output logic                 cmd_rd_o,
    output logic [DRP_AW-1:0]    cmd_addr_o,
    output logic [DRP_DW-1:0]    cmd_wdata_o
);

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic              sel;
        logic              rd;
        logic [DRP_AW-1:0] addr;
        logic [DRP_DW-1:0] data;
    } regs_t;

    localparam logic [AXI_AW-1:0] A_CTL  = AXI_AW'(OFS_CTL);
    localparam logic [AXI_AW-1:0] A_CMD  = AXI_AW'(OFS_CMD);
    localparam logic [AXI_AW-1:0] A_STAT = AXI_AW'(OFS_STAT);

    regs_t q, d;
    logic  hit_ctl, hit_cmd, take_cmd;
    logic  unused_bits;

    assign hit_ctl  = wr_fire_i && (wr_addr_i == A_CTL);
    assign hit_cmd  = wr_fire_i && (wr_addr_i == A_CMD);
    assign take_cmd = hit_cmd && !busy_i;

    assign cmd_rd_o    = wr_data_i[CMD_RD_BIT];
    assign cmd_addr_o  = wr_data_i[CMD_ADDR_LSB +: DRP_AW];
    assign cmd_wdata_o = wr_data_i[DRP_DW-1:0];
    assign ctl_o       = q.ctl;
    assign unused_bits = ^wr_data_i;

    always_comb begin
        d       = q;
        start_o = 1'b0;
        if (hit_ctl) begin
            d.ctl = wr_data_i[CTL_W-1:0];
        end
        if (take_cmd) begin
            d.sel   = wr_data_i[CMD_SEL_BIT];
            d.rd    = wr_data_i[CMD_RD_BIT];
            d.addr  = wr_data_i[CMD_ADDR_LSB +: DRP_AW];
            d.data  = wr_data_i[DRP_DW-1:0];
            start_o = wr_data_i[CMD_SEL_BIT];
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTL: begin
                rd_data_o[CTL_W-1:0] = q.ctl;
            end
            A_CMD: begin
                rd_data_o[CMD_SEL_BIT]                = q.sel;
                rd_data_o[CMD_RD_BIT]                 = q.rd;
                rd_data_o[CMD_ADDR_LSB +: DRP_AW]     = q.addr;
                rd_data_o[DRP_DW-1:0]                 = q.data;
            end
            A_STAT: begin
                rd_data_o[STAT_BUSY_BIT] = busy_i;
                rd_data_o[DRP_DW-1:0]    = cap_i;
            end
            default: begin
                rd_data_o = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/clkcfg_drp_seq.sv
module clkcfg_drp_seq
    import clkcfg_pkg::*;
#(
    parameter int unsigned DRP_AW = 7,
    parameter int unsigned DRP_DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rd_i,
    input  logic [DRP_AW-1:0]  addr_i,
    input  logic [DRP_DW-1:0]  wdata_i,
    output logic               busy_o,
    output logic [DRP_DW-1:0]  cap_o,
    output logic               drp_en_o,
    output logic               drp_we_o,
    output logic [DRP_AW-1:0]  drp_addr_o,
    output logic [DRP_DW-1:0]  drp_wdata_o,
    input  logic [DRP_DW-1:0]  drp_rdata_i,
    input  logic               drp_rdy_i
);

    typedef struct packed {
        seq_st_e           st;
        logic              en;
        logic              we;
        logic              rd;
        logic [DRP_AW-1:0] addr;
        logic [DRP_DW-1:0] wdata;
        logic [DRP_DW-1:0] cap;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d    = q;
        d.en = 1'b0;
        d.we = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    d.st    = SQ_WAIT;
                    d.en    = 1'b1;
                    d.we    = !rd_i;
                    d.rd    = rd_i;
                    d.addr  = addr_i;
                    d.wdata = wdata_i;
                end
            end
            SQ_WAIT: begin
                if (drp_rdy_i) begin
                    d.st = SQ_IDLE;
                    if (q.rd) begin
                        d.cap = drp_rdata_i;
                    end
                end
            end
            default: begin
                d.st = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st == SQ_WAIT);
    assign cap_o       = q.cap;
    assign drp_en_o    = q.en;
    assign drp_we_o    = q.we;
    assign drp_addr_o  = q.addr;
    assign drp_wdata_o = q.wdata;

endmodule

// File: rtl/clkcfg_bridge.sv
module clkcfg_bridge
    import clkcfg_pkg::*;
#(
    parameter int unsigned AXI_AW = 8,
    parameter int unsigned DRP_AW = 7,
    parameter int unsigned DRP_DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AXI_AW-1:0]  s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [31:0]        s_wdata,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [AXI_AW-1:0]  s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [31:0]        s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    output logic               gen_release_o,
    output logic               synth_en_o,
    output logic               drp_en_o,
    output logic               drp_we_o,
    output logic [DRP_AW-1:0]  drp_addr_o,
    output logic [DRP_DW-1:0]  drp_wdata_o,
    input  logic [DRP_DW-1:0]  drp_rdata_i,
    input  logic               drp_rdy_i
);

    logic                wr_fire;
    logic [AXI_AW-1:0]   wr_addr;
    logic [HOST_DW-1:0]  wr_data;
    logic [AXI_AW-1:0]   rd_addr;
    logic [HOST_DW-1:0]  rd_data;
    logic [CTL_W-1:0]    ctl;
    logic                seq_start;
    logic                seq_rd;
    logic [DRP_AW-1:0]   seq_addr;
    logic [DRP_DW-1:0]   seq_wdata;
    logic                seq_busy;
    logic [DRP_DW-1:0]   seq_cap;

    clkcfg_axil #(.AXI_AW(AXI_AW)) u_axil (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .wr_fire_o (wr_fire),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data)
    );

    clkcfg_regs #(.AXI_AW(AXI_AW), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire_i   (wr_fire),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .busy_i      (seq_busy),
        .cap_i       (seq_cap),
        .ctl_o       (ctl),
        .start_o     (seq_start),
        .cmd_rd_o    (seq_rd),
        .cmd_addr_o  (seq_addr),
        .cmd_wdata_o (seq_wdata)
    );

    clkcfg_drp_seq #(.DRP_AW(DRP_AW), .DRP_DW(DRP_DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (seq_start),
        .rd_i        (seq_rd),
        .addr_i      (seq_addr),
        .wdata_i     (seq_wdata),
        .busy_o      (seq_busy),
        .cap_o       (seq_cap),
        .drp_en_o    (drp_en_o),
        .drp_we_o    (drp_we_o),
        .drp_addr_o  (drp_addr_o),
        .drp_wdata_o (drp_wdata_o),
        .drp_rdata_i (drp_rdata_i),
        .drp_rdy_i   (drp_rdy_i)
    );

    assign gen_release_o = ctl[0];
    assign synth_en_o    = ctl[1];

endmodule

// File: rtl/clkcfg_bridge_chk.sv
module clkcfg_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic drp_en,
    input logic drp_we,
    input logic drp_rdy,
    input logic bvalid,
    input logic bready,
    input logic awready,
    input logic rvalid,
    input logic rready,
    input logic [31:0] rdata
);

    AST_EN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |=> !drp_en); // R3

    AST_WE_ONLY_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        drp_we |-> drp_en); // R3

    AST_EN_ON_NEW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |-> $rose(busy)); // R7

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && drp_rdy) |=> !busy); // R5

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !drp_rdy) |=> busy); // R5

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid); // R9

    AST_NO_AW_WHILE_B: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready); // R9

    AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R9

endmodule

bind clkcfg_bridge clkcfg_bridge_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (seq_busy),
    .drp_en  (drp_en_o),
    .drp_we  (drp_we_o),
    .drp_rdy (drp_rdy_i),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .awready (s_awready),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .rdata   (s_rdata)
);

// File: tb/tb_clkcfg_bridge.sv
`timescale 1ns/1ps
module tb_clkcfg_bridge;

    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b1;
    logic [AW-1:0] s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b1;
    logic        gen_release_o, synth_en_o, drp_en_o, drp_we_o;
    logic [6:0]  drp_addr_o;
    logic [15:0] drp_wdata_o;
    logic [15:0] drp_rdata_i;
    logic        drp_rdy_i;

    always #4 clk = ~clk;

    clkcfg_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .gen_release_o(gen_release_o), .synth_en_o(synth_en_o),
        .drp_en_o(drp_en_o), .drp_we_o(drp_we_o), .drp_addr_o(drp_addr_o),
        .drp_wdata_o(drp_wdata_o), .drp_rdata_i(drp_rdata_i), .drp_rdy_i(drp_rdy_i)
    );

    // Port register-file model
    logic [15:0] mdl_mem [128];
    int          mdl_lat = 2;
    logic        mdl_pend = 1'b0;
    int          mdl_cnt = 0;
    logic [6:0]  mdl_addr = '0;
    logic        mdl_we = 1'b0;
    logic [15:0] mdl_wd = '0;
    logic        mdl_rdy = 1'b0;
    logic [15:0] mdl_rd = '0;
    int          en_cnt = 0;

    assign drp_rdy_i   = mdl_rdy;
    assign drp_rdata_i = mdl_rd;

    always @(posedge clk) begin
        mdl_rdy <= 1'b0;
        if (!rst_n) begin
            mdl_pend <= 1'b0;
        end else if (drp_en_o) begin
            en_cnt   <= en_cnt + 1;
            mdl_pend <= 1'b1;
            mdl_cnt  <= mdl_lat;
            mdl_addr <= drp_addr_o;
            mdl_we   <= drp_we_o;
            mdl_wd   <= drp_wdata_o;
        end else if (mdl_pend) begin
            if (mdl_cnt == 0) begin
                mdl_rdy  <= 1'b1;
                mdl_rd   <= mdl_mem[mdl_addr];
                if (mdl_we) mdl_mem[mdl_addr] <= mdl_wd;
                mdl_pend <= 1'b0;
            end else begin
                mdl_cnt <= mdl_cnt - 1;
            end
        end
    end

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input bit sel, input bit rd,
                                           input logic [6:0] a, input logic [15:0] dat);
        logic [31:0] w;
        w = '0;
        w[29] = sel;
        w[28] = rd;
        w[22:16] = a;
        w[15:0] = dat;
        return w;
    endfunction

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] dat);
        bit acc;
        s_awaddr = a; s_wdata = dat; s_awvalid = 1'b1; s_wvalid = 1'b1; s_bready = 1'b1;
        acc = 1'b0;
        while (!acc) begin
            #1 acc = s_awready && s_wready;
            @(negedge clk);
        end
        s_awvalid = 1'b0; s_wvalid = 1'b0;
    endtask

    task automatic axi_read(input logic [AW-1:0] a, output logic [31:0] dat,
                            output logic [1:0] resp);
        bit acc;
        s_araddr = a; s_arvalid = 1'b1; s_rready = 1'b1;
        acc = 1'b0;
        while (!acc) begin
            #1 acc = s_arready;
            @(negedge clk);
        end
        dat = s_rdata; resp = s_rresp;
        s_arvalid = 1'b0;
    endtask

    task automatic wait_rdy();
        for (int i = 0; i < 100; i++) begin
            if (drp_rdy_i) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v; logic [1:0] r;
        chk(!gen_release_o && !synth_en_o, "R1", "reset outputs", {30'b0, synth_en_o, gen_release_o}, 0);
        chk(!drp_en_o && !drp_we_o, "R1", "port idle", {30'b0, drp_we_o, drp_en_o}, 0);
        chk(!s_bvalid && !s_rvalid, "R1", "no response", {30'b0, s_rvalid, s_bvalid}, 0);
        axi_read(8'h40, v, r); chk(v == 0, "R1", "control reads 0", v, 0);
        axi_read(8'h74, v, r); chk(v == 0, "R1", "status reads 0", v, 0);
    endtask

    task automatic t_ctl();
        logic [31:0] v; logic [1:0] r;
        axi_write(8'h40, 32'h1);
        chk(gen_release_o && !synth_en_o, "R2", "release only", {30'b0, synth_en_o, gen_release_o}, 1);
        axi_write(8'h40, 32'h3);
        chk(gen_release_o && synth_en_o, "R2", "both on", {30'b0, synth_en_o, gen_release_o}, 3);
        axi_read(8'h40, v, r); chk(v == 3, "R2", "readback", v, 3);
        axi_write(8'h40, 32'h1);
        chk(gen_release_o && !synth_en_o, "R2", "disable synth", {30'b0, synth_en_o, gen_release_o}, 1);
        axi_write(8'h40, 32'hFFFF_FFFC);
        axi_read(8'h40, v, r); chk(v == 0, "R2", "upper bits dropped", v, 0);
        axi_write(8'h40, 32'h3);
    endtask

    task automatic t_drp_read();
        logic [31:0] v; logic [1:0] r;
        mdl_mem[7'h2A] = 16'h1234;
        mdl_lat = 3;
        axi_write(8'h70, mk_cmd(1, 1, 7'h2A, 16'hFFFF));
        chk(drp_en_o && !drp_we_o && drp_addr_o == 7'h2A, "R4", "read strobe",
            {23'b0, drp_en_o, drp_we_o, drp_addr_o}, {23'b0, 2'b10, 7'h2A});
        @(negedge clk);
        chk(!drp_en_o, "R4", "strobe one cycle", {31'b0, drp_en_o}, 0);
        wait_rdy();
        axi_read(8'h74, v, r);
        chk(v == 32'h0001_0000, "R5", "busy at ready edge", v, 32'h0001_0000);
        axi_read(8'h74, v, r);
        chk(v == 32'h0000_1234, "R4", "read data captured", v, 32'h0000_1234);
    endtask

    task automatic t_drp_write();
        logic [31:0] v; logic [1:0] r;
        mdl_lat = 2;
        axi_write(8'h70, mk_cmd(1, 0, 7'h15, 16'hBEEF));
        chk(drp_en_o && drp_we_o, "R3", "write strobe", {30'b0, drp_en_o, drp_we_o}, 3);
        chk(drp_addr_o == 7'h15 && drp_wdata_o == 16'hBEEF, "R3", "addr/data",
            {9'b0, drp_addr_o, drp_wdata_o}, {9'b0, 7'h15, 16'hBEEF});
        axi_read(8'h74, v, r);
        chk(v[16] == 1'b1, "R5", "busy after start", v, 32'h0001_0000);
        chk(!drp_en_o && !drp_we_o, "R3", "strobe dropped", {30'b0, drp_en_o, drp_we_o}, 0);
        wait_rdy();
        @(negedge clk); @(negedge clk);
        chk(mdl_mem[7'h15] == 16'hBEEF, "R3", "model written", {16'b0, mdl_mem[7'h15]}, 32'hBEEF);
        axi_read(8'h74, v, r);
        chk(v == 32'h0000_1234, "R10", "status keeps read data", v, 32'h0000_1234);
    endtask

    task automatic t_nosel();
        logic [31:0] v; logic [1:0] r; int c0;
        c0 = en_cnt;
        axi_write(8'h70, mk_cmd(0, 1, 7'h2A, 16'h0));
        repeat (6) @(negedge clk);
        chk(en_cnt == c0, "R6", "no access", en_cnt, c0);
        axi_read(8'h74, v, r);
        chk(v[16] == 1'b0, "R6", "busy stays clear", v, 32'h0000_1234);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v; logic [1:0] r; int c0;
        mdl_mem[7'h33] = 16'hA5A5;
        mdl_mem[7'h40] = 16'h0F0F;
        mdl_lat = 8;
        c0 = en_cnt;
        axi_write(8'h70, mk_cmd(1, 1, 7'h33, 16'h0));
        axi_write(8'h70, mk_cmd(1, 0, 7'h40, 16'h5555));
        axi_read(8'h70, v, r);
        chk(v == mk_cmd(1, 1, 7'h33, 16'h0), "R7", "command unchanged", v, mk_cmd(1, 1, 7'h33, 16'h0));
        wait_rdy();
        repeat (6) @(negedge clk);
        chk(en_cnt == c0 + 1, "R7", "single access", en_cnt, c0 + 1);
        chk(mdl_mem[7'h40] == 16'h0F0F, "R7", "second write dropped", {16'b0, mdl_mem[7'h40]}, 32'h0F0F);
        axi_read(8'h74, v, r);
        chk(v == 32'h0000_A5A5, "R7", "first read intact", v, 32'h0000_A5A5);
    endtask

    task automatic t_unmapped();
        logic [31:0] v; logic [1:0] r; int c0;
        c0 = en_cnt;
        axi_read(8'h00, v, r); chk(v == 0 && r == 0, "R8", "read 0x00", v, 0);
        axi_read(8'h7C, v, r); chk(v == 0 && r == 0, "R8", "read 0x7C", v, 0);
        axi_write(8'h48, 32'hFFFF_FFFF);
        chk(s_bresp == 2'b00, "R8", "write OKAY", {30'b0, s_bresp}, 0);
        axi_read(8'h40, v, r); chk(v == 3, "R8", "control untouched", v, 3);
        chk(en_cnt == c0, "R8", "nothing started", en_cnt, c0);
    endtask

    task automatic t_hold();
        logic [31:0] v; logic [1:0] r;
        s_bready = 1'b0;
        s_awaddr = 8'h40; s_wdata = 32'h3; s_awvalid = 1'b1; s_wvalid = 1'b1;
        @(negedge clk);
        s_wdata = 32'h0;
        repeat (3) @(negedge clk);
        chk(s_bvalid == 1'b1, "R9", "bvalid held", {31'b0, s_bvalid}, 1);
        chk(synth_en_o == 1'b1, "R9", "no write while pending", {31'b0, synth_en_o}, 1);
        s_awvalid = 1'b0; s_wvalid = 1'b0; s_bready = 1'b1;
        @(negedge clk);
        chk(s_bvalid == 1'b0, "R9", "bvalid released", {31'b0, s_bvalid}, 0);
        s_rready = 1'b0;
        s_araddr = 8'h40; s_arvalid = 1'b1;
        @(negedge clk);
        s_arvalid = 1'b0;
        repeat (3) @(negedge clk);
        chk(s_rvalid && s_rdata == 3, "R9", "rvalid and data held", s_rdata, 3);
        s_rready = 1'b1;
        @(negedge clk);
        chk(!s_rvalid, "R9", "rvalid released", {31'b0, s_rvalid}, 0);
        axi_read(8'h40, v, r);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mdl_mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_drp_read();
        t_drp_write();
        t_nosel();
        t_busy_ignore();
        t_unmapped();
        t_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule